// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Flag Generation

This block is the combinational arithmetic and logic stage of an accumulator-style 8-bit processor. In one pass it takes a 4-bit operation code, the accumulator, a second operand and the current flag byte. It returns the new accumulator value and the new flag byte. No clock passes through the block. The surrounding datapath decides whether to write either output back.

The operations are:

- add and add-with-carry
- subtract and subtract-with-borrow
- compare
- AND, OR and XOR
- two's-complement negate and one's-complement invert
- decimal adjust after BCD arithmetic
- set-carry and toggle-carry

The flag byte has this layout, from bit 7 down to bit 0:

- sign
- zero
- copy of result bit 5
- half-carry
- copy of result bit 3
- parity/overflow
- subtract
- carry

Compare is the one operation that takes its two copy bits from the operand and not from the result. The two carry-manipulation operations instead OR the accumulator bits into the incoming copy bits.

Top module: `alu8_core`

## Requirements
- R1: Operation codes on `op_i` are: 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 compare, 5 AND, 6 OR, 7 XOR, 8 negate, 9 invert, 10 decimal adjust, 11 set-carry, 12 toggle-carry. For code 0, `res_o` = (A + B) mod 256. For code 1, `res_o` = (A + B + cin) mod 256, where cin is bit 0 of `flags_i`.
- R2: For code 2, `res_o` = (A − B) mod 256. For code 3, `res_o` = (A − B − cin) mod 256. For code 8, `res_o` = (0 − A) mod 256.
- R3: Flag bit 7 (sign) equals bit 7 of the result. Flag bit 6 (zero) is set exactly when the 8-bit result is zero. This holds for codes 0–3 and 5–8 and 10. For code 4, both bits come from the discarded difference.
- R4: Flag bit 4 (half) is the carry or borrow out of bit 3. Flag bit 0 (carry) is the carry or borrow out of bit 7. This holds for codes 0–4 and 8.
- R5: Flag bit 2 is signed overflow for codes 0–4 and 8. For codes 5–7 and 10, it is set when the result has an even number of one bits.
- R6: Flag bit 1 (subtract) is 1 for codes 2, 3, 4 and 8. It is 0 for codes 0, 1, 5, 6 and 7.
- R7: AND sets flag bit 4. OR and XOR clear flag bit 4. All three clear flag bit 0.
- R8: Compare leaves `res_o` equal to A. Its flags are those of A − B, except that flag bits 5 and 3 are copies of B bits 5 and 3.
- R9: For codes 0–3, 5–8 and 10, flag bits 5 and 3 copy result bits 5 and 3.
- R10: Decimal adjust works in two parts.
  - The correction has a low part of 0x06 and a high part of 0x60. The low part applies when flag bit 4 is set or A[3:0] > 9. The high part applies when flag bit 0 is set or A > 0x99.
  - The correction is subtracted when flag bit 1 is set and added otherwise.
  - New carry = old carry OR (A > 0x99). New half = A[4] XOR result[4]. Flag bit 1 is kept.
- R11: Invert gives `res_o` = ~A and sets flag bits 4 and 1. It keeps flag bits 7, 6, 2 and 0.
- R12: Set-carry sets bit 0 and clears bits 4 and 1. Toggle-carry copies the old bit 0 into bit 4, inverts bit 0 and clears bit 1. For both, `res_o` = A, flag bits 5 and 3 become the incoming flag bit ORed with the matching A bit, and bits 7, 6 and 2 are kept.
- R13: Codes 13–15 are inert: `res_o` = A and `flags_o` = `flags_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code |
| acc_i | input | 8 | Accumulator value A |
| opnd_i | input | 8 | Second operand B |
| flags_i | input | 8 | Incoming flag byte |
| res_o | output | 8 | New accumulator value |
| flags_o | output | 8 | New flag byte |

## Verification
The hardest corners to reach are decimal adjust and subtract-with-borrow.

- **Decimal adjust.** Its output depends on all three incoming flag bits (half, subtract, carry) together with the accumulator value. Flag states that a real instruction stream rarely produces, such as subtract set with a low nibble above 9, only appear when the flag byte is driven directly.
- **Subtract-with-borrow.** The operand 0xFF with borrow-in set is where the borrow logic is most likely to wrap wrongly.

The stimulus reaches these corners by enumerating the full flag byte against every accumulator value for the single-operand operations. For the two-operand operations, it enumerates every operand pair with carry-in 0 and 1. Each response is compared with an independent model.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int DW  = 8;
  localparam int OPW = 4;
  localparam int NIB = DW / 2;

  typedef enum logic [OPW-1:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_SBC = 4'd3,
    OP_CMP = 4'd4,
    OP_AND = 4'd5,
    OP_OR  = 4'd6,
    OP_XOR = 4'd7,
    OP_NEG = 4'd8,
    OP_CPL = 4'd9,
    OP_DAA = 4'd10,
    OP_SCF = 4'd11,
    OP_CCF = 4'd12
  } alu_op_e;

  // flag byte bit positions
  localparam int FB_S = 7;
  localparam int FB_Z = 6;
  localparam int FB_X = 5;
  localparam int FB_H = 4;
  localparam int FB_Y = 3;
  localparam int FB_P = 2;
  localparam int FB_N = 1;
  localparam int FB_C = 0;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2
  } logic_sel_e;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int W   = 8,
  parameter int NIB = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         half_o,
  output logic         carry_o,
  output logic         ovf_o
);

  logic [W:0]   wide;
  logic [NIB:0] low;
  logic         sign_diff;
  logic         res_flip;

  always_comb begin
    if (sub_i) begin
      wide = {1'b0, a_i} - {1'b0, b_i} - {{W{1'b0}}, cin_i};
      low  = {1'b0, a_i[NIB-1:0]} - {1'b0, b_i[NIB-1:0]} - {{NIB{1'b0}}, cin_i};
    end else begin
      wide = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
      low  = {1'b0, a_i[NIB-1:0]} + {1'b0, b_i[NIB-1:0]} + {{NIB{1'b0}}, cin_i};
    end
    sign_diff = a_i[W-1] ^ b_i[W-1];
    res_flip  = wide[W-1] ^ a_i[W-1];
    sum_o     = wide[W-1:0];
    half_o    = low[NIB];
    carry_o   = wide[W];
    ovf_o     = sub_i ? (sign_diff & res_flip) : (~sign_diff & res_flip);
  end

  always_comb begin
    if (sub_i) begin
      AST_BORROW_OUT: assert (carry_o == ({1'b0, a_i} < ({1'b0, b_i} + {{W{1'b0}}, cin_i}))) else $error("borrow mismatch"); // R4
    end else begin
      AST_CARRY_OUT: assert (carry_o == (({1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i}) > {1'b0, {W{1'b1}}})) else $error("carry mismatch"); // R4
    end
  end

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [1:0]   sel_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o,
  output logic         even_o
);

  always_comb begin
    case (sel_i)
      LG_AND:  res_o = a_i & b_i;
      LG_OR:   res_o = a_i | b_i;
      default: res_o = a_i ^ b_i;
    endcase
    even_o = ~(^res_o);
  end

  always_comb begin
    if (sel_i == LG_AND) begin
      AST_AND_SUBSET: assert ((res_o & ~a_i) == '0) else $error("and exceeds operand"); // R7
    end
    if (sel_i == LG_OR) begin
      AST_OR_SUPERSET: assert ((a_i & ~res_o) == '0) else $error("or drops bits"); // R7
    end
  end

endmodule

// File: rtl/alu8_decadj.sv
module alu8_decadj #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic         h_i,
  input  logic         n_i,
  input  logic         c_i,
  output logic [W-1:0] res_o,
  output logic         h_o,
  output logic         c_o
);

  localparam logic [W-1:0] LO_FIX = W'(8'h06);
  localparam logic [W-1:0] HI_FIX = W'(8'h60);
  localparam logic [W-1:0] HI_LIM = W'(8'h99);

  logic         fix_lo;
  logic         fix_hi;
  logic [W-1:0] corr;

  always_comb begin
    fix_lo = h_i | (a_i[3:0] > 4'd9);
    fix_hi = c_i | (a_i > HI_LIM);
    corr   = (fix_hi ? HI_FIX : '0) | (fix_lo ? LO_FIX : '0);
    res_o  = n_i ? (a_i - corr) : (a_i + corr);
    h_o    = a_i[4] ^ res_o[4];
    c_o    = fix_hi;
  end

  always_comb begin
    if (!h_i && !c_i && (a_i[3:0] <= 4'd9) && (a_i[7:4] <= 4'd9)) begin
      AST_DAA_VALID_BCD: assert (res_o == a_i && !c_o) else $error("valid bcd altered"); // R10
    end
    if (c_i) begin
      AST_DAA_CARRY_STICKY: assert (c_o) else $error("carry lost"); // R10
    end
  end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int W = DW
) (
  input  logic [3:0] op_i,
  input  logic [7:0] acc_i,
  input  logic [7:0] opnd_i,
  input  logic [7:0] flags_i,
  output logic [7:0] res_o,
  output logic [7:0] flags_o
);

  // adder path
  logic [W-1:0] as_a, as_b, as_sum;
  logic         as_cin, as_sub, as_half, as_carry, as_ovf;
  // logic path
  logic [1:0]   lg_sel;
  logic [W-1:0] lg_res;
  logic         lg_even;
  // decimal adjust path
  logic [W-1:0] da_res;
  logic         da_h, da_c;

  always_comb begin
    as_a   = (op_i == OP_NEG) ? '0 : acc_i;
    as_b   = (op_i == OP_NEG) ? acc_i : opnd_i;
    as_sub = (op_i == OP_SUB) || (op_i == OP_SBC) || (op_i == OP_CMP) || (op_i == OP_NEG);
    as_cin = ((op_i == OP_ADC) || (op_i == OP_SBC)) && flags_i[FB_C];
    case (op_i)
      OP_AND:  lg_sel = LG_AND;
      OP_OR:   lg_sel = LG_OR;
      default: lg_sel = LG_XOR;
    endcase
  end

  alu8_addsub #(.W(W), .NIB(NIB)) u_addsub (
    .a_i     (as_a),
    .b_i     (as_b),
    .cin_i   (as_cin),
    .sub_i   (as_sub),
    .sum_o   (as_sum),
    .half_o  (as_half),
    .carry_o (as_carry),
    .ovf_o   (as_ovf)
  );

  alu8_logic #(.W(W)) u_logic (
    .sel_i  (lg_sel),
    .a_i    (acc_i),
    .b_i    (opnd_i),
    .res_o  (lg_res),
    .even_o (lg_even)
  );

  alu8_decadj #(.W(W)) u_decadj (
    .a_i   (acc_i),
    .h_i   (flags_i[FB_H]),
    .n_i   (flags_i[FB_N]),
    .c_i   (flags_i[FB_C]),
    .res_o (da_res),
    .h_o   (da_h),
    .c_o   (da_c)
  );

  always_comb begin
    res_o   = acc_i;
    flags_o = flags_i;
    case (op_i)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG: begin
        res_o   = as_sum;
        flags_o = {as_sum[7], (as_sum == '0), as_sum[5], as_half,
                   as_sum[3], as_ovf, as_sub, as_carry};
      end
      OP_CMP: begin
        res_o   = acc_i;
        flags_o = {as_sum[7], (as_sum == '0), opnd_i[5], as_half,
                   opnd_i[3], as_ovf, 1'b1, as_carry};
      end
      OP_AND, OP_OR, OP_XOR: begin
        res_o   = lg_res;
        flags_o = {lg_res[7], (lg_res == '0), lg_res[5], (op_i == OP_AND),
                   lg_res[3], lg_even, 1'b0, 1'b0};
      end
      OP_CPL: begin
        res_o   = ~acc_i;
        flags_o = {flags_i[FB_S], flags_i[FB_Z], ~acc_i[5], 1'b1,
                   ~acc_i[3], flags_i[FB_P], 1'b1, flags_i[FB_C]};
      end
      OP_DAA: begin
        res_o   = da_res;
        flags_o = {da_res[7], (da_res == '0), da_res[5], da_h,
                   da_res[3], ~(^da_res), flags_i[FB_N], da_c};
      end
      OP_SCF: begin
        flags_o = {flags_i[FB_S], flags_i[FB_Z], flags_i[FB_X] | acc_i[5], 1'b0,
                   flags_i[FB_Y] | acc_i[3], flags_i[FB_P], 1'b0, 1'b1};
      end
      OP_CCF: begin
        flags_o = {flags_i[FB_S], flags_i[FB_Z], flags_i[FB_X] | acc_i[5], flags_i[FB_C],
                   flags_i[FB_Y] | acc_i[3], flags_i[FB_P], 1'b0, ~flags_i[FB_C]};
      end
      default: begin
        res_o   = acc_i;
        flags_o = flags_i;
      end
    endcase
  end

  always_comb begin
    if (op_i == OP_CMP) begin
      AST_CMP_KEEPS_ACC: assert (res_o == acc_i && flags_o[FB_N]) else $error("compare altered acc"); // R8
    end
    if (op_i == OP_CPL || op_i == OP_SCF || op_i == OP_CCF) begin
      AST_SZP_UNTOUCHED: assert (flags_o[FB_S] == flags_i[FB_S] && flags_o[FB_Z] == flags_i[FB_Z] && flags_o[FB_P] == flags_i[FB_P]) else $error("sign/zero/parity moved"); // R11 R12
    end
    if (op_i > 4'd12) begin
      AST_RESERVED_INERT: assert (res_o == acc_i && flags_o == flags_i) else $error("reserved code acted"); // R13
    end
    if (op_i == OP_ADD || op_i == OP_SUB || op_i == OP_AND || op_i == OP_XOR) begin
      AST_ZERO_TRACKS_RES: assert (flags_o[FB_Z] == (res_o == '0)) else $error("zero flag mismatch"); // R3
    end
  end

endmodule

// File: tb/alu8_core_bench.sv
`timescale 1ns/1ps
module alu8_core_bench;

  logic       clk;
  logic [3:0] op;
  logic [7:0] acc, opnd, fin;
  logic [7:0] res, fout;
  int         n_checks = 0;
  int         n_errors = 0;
  bit         done = 0;

  alu8_core u_alu8_core (
    .op_i    (op),
    .acc_i   (acc),
    .opnd_i  (opnd),
    .flags_i (fin),
    .res_o   (res),
    .flags_o (fout)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  // {op, a, b, f, expected result, expected flags}
  localparam logic [47:0] VEC [18] = '{
    {8'd0,  8'h0F, 8'h01, 8'h00, 8'h10, 8'h10},  // R1 R4 half carry
    {8'd0,  8'h7F, 8'h01, 8'h00, 8'h80, 8'h94},  // R5 overflow
    {8'd0,  8'hFF, 8'h01, 8'h00, 8'h00, 8'h51},  // R3 R4 wrap to zero
    {8'd1,  8'h10, 8'h20, 8'h01, 8'h31, 8'h20},  // R1 R9 carry in
    {8'd2,  8'h00, 8'h01, 8'h00, 8'hFF, 8'hBB},  // R2 R6 borrow
    {8'd3,  8'h80, 8'h00, 8'h01, 8'h7F, 8'h3E},  // R2 R5 signed underflow
    {8'd4,  8'h40, 8'h28, 8'h00, 8'h40, 8'h3A},  // R8 copies from operand
    {8'd5,  8'hF0, 8'h3C, 8'h00, 8'h30, 8'h34},  // R7 and
    {8'd6,  8'h00, 8'h00, 8'hFF, 8'h00, 8'h44},  // R7 or clears carry
    {8'd7,  8'hFF, 8'h01, 8'h00, 8'hFE, 8'hA8},  // R5 odd parity
    {8'd8,  8'h80, 8'h00, 8'h00, 8'h80, 8'h87},  // R2 negate of min
    {8'd8,  8'h00, 8'h00, 8'h00, 8'h00, 8'h42},  // R2 negate of zero
    {8'd9,  8'h5A, 8'h00, 8'h00, 8'hA5, 8'h32},  // R11
    {8'd10, 8'h9A, 8'h00, 8'h00, 8'h00, 8'h55},  // R10 both fixes added
    {8'd10, 8'h0F, 8'h00, 8'h02, 8'h09, 8'h0E},  // R10 low fix subtracted
    {8'd11, 8'h28, 8'h00, 8'h12, 8'h28, 8'h29},  // R12 set carry
    {8'd12, 8'h00, 8'h00, 8'hC5, 8'h00, 8'hD4},  // R12 toggle carry
    {8'd13, 8'h77, 8'h00, 8'h5A, 8'h77, 8'h5A}   // R13 reserved
  };

  function automatic string op_tag(int o);
    case (o)
      0, 1:       return "R1";
      2, 3, 8:    return "R2";
      4:          return "R8";
      5, 6, 7:    return "R7";
      9:          return "R11";
      10:         return "R10";
      11, 12:     return "R12";
      default:    return "R13";
    endcase
  endfunction

  function automatic string flag_tag(int o);
    case (o)
      0, 1, 2, 3, 8: return "R3 R4 R5 R6 R9";
      4:             return "R8";
      5, 6, 7:       return "R7 R5";
      9:             return "R11";
      10:            return "R10";
      11, 12:        return "R12";
      default:       return "R13";
    endcase
  endfunction

  function automatic int ones(int v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += (v >> i) & 1;
    return n;
  endfunction

  function automatic int common(int r);
    return (r & 8'hA8) | ((r == 0) ? 8'h40 : 0);
  endfunction

  function automatic int sgn(int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  // returns {result, flags}
  function automatic int model(int o, int a, int b, int f);
    int x, y, c, t, r, fl, hs, sv;
    bit sub;
    r = a; fl = f;
    case (o)
      0, 1, 2, 3, 4, 8: begin
        x   = (o == 8) ? 0 : a;
        y   = (o == 8) ? a : b;
        c   = (o == 1 || o == 3) ? (f & 1) : 0;
        sub = (o == 2 || o == 3 || o == 4 || o == 8);
        if (sub) begin
          t = x - y - c; hs = (x % 16) - (y % 16) - c; sv = sgn(x) - sgn(y) - c;
        end else begin
          t = x + y + c; hs = (x % 16) + (y % 16) + c; sv = sgn(x) + sgn(y) + c;
        end
        r  = t & 255;
        fl = common(r);
        if (hs < 0 || hs > 15) fl |= 8'h10;
        if (sv > 127 || sv < -128) fl |= 8'h04;
        if (sub) fl |= 8'h02;
        if (t < 0 || t > 255) fl |= 8'h01;
        if (o == 4) begin
          fl = (fl & ~8'h28) | (b & 8'h28);
          r  = a;
        end
      end
      5, 6, 7: begin
        r  = (o == 5) ? (a & b) : (o == 6) ? (a | b) : (a ^ b);
        fl = common(r) | ((ones(r) % 2 == 0) ? 8'h04 : 0) | ((o == 5) ? 8'h10 : 0);
      end
      9: begin
        r  = (~a) & 255;
        fl = (f & 8'hC5) | (r & 8'h28) | 8'h12;
      end
      10: begin
        c = 0;
        if (((f >> 4) & 1) == 1 || (a % 16) > 9) c += 6;
        if ((f & 1) == 1 || a > 8'h99) c += 8'h60;
        t  = ((f & 2) != 0) ? a - c : a + c;
        r  = t & 255;
        fl = common(r) | ((ones(r) % 2 == 0) ? 8'h04 : 0) | (f & 2);
        if ((f & 1) == 1 || a > 8'h99) fl |= 1;
        if ((((a >> 4) ^ (r >> 4)) & 1) == 1) fl |= 8'h10;
      end
      11: fl = (f & 8'hC4) | ((f | a) & 8'h28) | 1;
      12: fl = (f & 8'hC4) | ((f | a) & 8'h28) | ((f & 1) << 4) | ((f & 1) ^ 1);
      default: begin r = a; fl = f; end
    endcase
    return (r << 8) | fl;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s op=%0d a=%02h b=%02h f=%02h actual=%02h expected=%02h",
               tag, op, acc, opnd, fin, act, exp);
    end
  endtask

  task automatic apply(int o, int a, int b, int f);
    op = 4'(o); acc = 8'(a); opnd = 8'(b); fin = 8'(f);
    #1;
  endtask

  task automatic sweep(int o, int a, int b, int f);
    int m;
    apply(o, a, b, f);
    m = model(o, a, b, f);
    check(op_tag(o), int'(res), (m >> 8) & 255);
    check(flag_tag(o), int'(fout), m & 255);
  endtask

  initial begin
    op = 0; acc = 0; opnd = 0; fin = 0;
    #5;
    // directed table
    for (int i = 0; i < 18; i++) begin
      apply(int'(VEC[i][47:40]), int'(VEC[i][39:32]), int'(VEC[i][31:24]), int'(VEC[i][23:16]));
      check(op_tag(int'(VEC[i][47:40])), int'(res), int'(VEC[i][15:8]));
      check(flag_tag(int'(VEC[i][47:40])), int'(fout), int'(VEC[i][7:0]));
    end
    // two-operand operations: every pair, carry-in 0 and 1
    for (int o = 0; o < 8; o++)
      for (int a = 0; a < 256; a++)
        for (int b = 0; b < 256; b++)
          for (int c = 0; c < 2; c++)
            sweep(o, a, b, c | ((a ^ b) & 8'hFE));
    // single-operand and reserved codes: every accumulator against every flag byte
    for (int o = 8; o < 16; o++)
      for (int a = 0; a < 256; a++)
        for (int f = 0; f < 256; f++)
          sweep(o, a, a ^ 8'h5A, f);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end

endmodule